// File: doc/BRIEF.md
# Streamed Event Counter Bank

This block keeps a bank of accumulating counters in on-chip memory. Increment events arrive on a stream sink: each beat carries an amount and a counter index, and the block adds that amount to the selected counter. The add is a read-modify-write spread over a configurable number of register stages. When a beat targets a counter whose previous update has not yet reached memory, the block forwards the newer result, so updates that arrive back to back are never lost.

A separate read-only register port serves counter values over AXI4-Lite. Each counter occupies an aligned slot of the address space. A counter wider than the bus is split into bus words, with the least significant word at the lowest address. Writes on the register port are acknowledged and then discarded. After reset the block clears its memory by walking every index, and it accepts no increments until that walk is done.

Top module: `evcnt_bank`

## Requirements
- R1: After reset is released, the block writes zero to one counter per clock, in index order. `inc_ready` stays low during reset and rises on exactly the 2^ID_W-th rising edge after reset goes low. From then on, every counter reads zero until it is incremented.
- R2: An increment beat is accepted on a rising edge where `inc_valid` and `inc_ready` are both high. Each accepted beat adds the zero-extended `inc_amount` to counter `inc_id`. No other counter changes.
- R3: Beats to the same index accumulate with no lost update. This holds when they arrive on consecutive cycles, when they are interleaved with beats to other indices, and when a running total carries across a bus-word boundary.
- R4: Counters wrap modulo 2^CNT_W. For example, with CNT_W=16, the amount 0xFFFF followed by 0x0003 leaves the value 0x0002.
- R5: Counter n occupies the byte slot starting at n*S, where S = max(CNT_W/8, BUS_W/8). Bus word k of the slot holds counter bits [k*BUS_W +: BUS_W], so the least significant word sits at the lowest address. Address bits below the bus word size are ignored. When CNT_W < BUS_W, the unused upper bits read as zero.
- R6: `lite_rvalid` rises on the clock edge that accepts the AR handshake. `lite_rresp` is OKAY (2'b00). While `lite_rvalid` is held without `lite_rready`, `lite_rdata` stays stable and `lite_arready` stays low.
- R7: The AW and W beats of a write may arrive in either order, or together. Exactly one response with `lite_bresp` = OKAY (2'b00) follows on the edge that completes the pair, and it is held until `lite_bready`. No counter value changes because of a write.
- R8: Once `inc_ready` has risen, it stays high and the block accepts one beat per cycle, with or without register-port reads in progress. Counter reads never stall the increment path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_valid | input | 1 | Increment beat valid |
| inc_ready | output | 1 | Increment beat ready (low until the clear walk ends) |
| inc_amount | input | INC_W | Amount to add |
| inc_id | input | ID_W | Index of the counter to increment |
| lite_awaddr | input | ADDR_W | Write address (ignored) |
| lite_awvalid | input | 1 | Write address valid |
| lite_awready | output | 1 | Write address ready |
| lite_wdata | input | BUS_W | Write data (ignored) |
| lite_wstrb | input | BUS_W/8 | Write strobes (ignored) |
| lite_wvalid | input | 1 | Write data valid |
| lite_wready | output | 1 | Write data ready |
| lite_bresp | output | 2 | Write response, always OKAY |
| lite_bvalid | output | 1 | Write response valid |
| lite_bready | input | 1 | Write response ready |
| lite_araddr | input | ADDR_W | Read byte address |
| lite_arvalid | input | 1 | Read address valid |
| lite_arready | output | 1 | Read address ready |
| lite_rdata | output | BUS_W | Read data |
| lite_rresp | output | 2 | Read response, always OKAY |
| lite_rvalid | output | 1 | Read data valid |
| lite_rready | input | 1 | Read data ready |

## Verification
The embedded properties check the cycle-level rules on every cycle:
- the clear walk steps one index per clock and is never overlapped by an update;
- two updates to one index on consecutive edges differ by exactly the newer amount, which is the forwarding rule;
- `inc_ready` never drops once raised;
- read and write responses appear on time and are held until taken.

Only the bench scenarios can show the following, because each depends on a full history of beats that no single-cycle property can see:
- the final totals after long same-index runs, interleaving and a carry into the upper bus word;
- the wrap of a narrow counter;
- the address map, including the ignored low address bits;
- the fact that writes leave counters untouched.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

   localparam logic [1:0] RESP_OKAY = 2'b00;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // bytes of address space given to each counter
   function automatic int slot_bytes(input int cnt_w, input int bus_w);
      return max_i(cnt_w / 8, bus_w / 8);
   endfunction

   function automatic int slot_lg(input int cnt_w, input int bus_w);
      return $clog2(slot_bytes(cnt_w, bus_w));
   endfunction

endpackage

// File: rtl/evcnt_mem.sv
// Counter storage: one write port, one free-running read port for the
// update path and one enabled read port for the register side.
module evcnt_mem #(
   parameter int W  = 64,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] a_addr,
   output logic [W-1:0]  a_q,
   input  logic          b_en,
   input  logic [AW-1:0] b_addr,
   output logic [W-1:0]  b_q
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      a_q <= store[a_addr];
      if (b_en) b_q <= store[b_addr];
   end

endmodule

// File: rtl/evcnt_update.sv
// Clear walk plus pipelined read-modify-write with result forwarding.
module evcnt_update #(
   parameter int CNT_W = 64,
   parameter int INC_W = 16,
   parameter int ID_W  = 8,
   parameter int PIPE  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [ID_W-1:0]  in_id,
   input  logic [INC_W-1:0] in_inc,
   output logic [ID_W-1:0]  rd_addr,
   input  logic [CNT_W-1:0] rd_data,
   output logic             wr_en,
   output logic [ID_W-1:0]  wr_addr,
   output logic [CNT_W-1:0] wr_data
);
   localparam int LAST = PIPE - 1;

   // ---------------- clear walk ----------------
   logic            sweeping;
   logic [ID_W-1:0] sweep_idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         sweeping  <= 1'b1;
         sweep_idx <= '0;
      end else if (sweeping) begin
         sweep_idx <= sweep_idx + 1'b1;
         if (sweep_idx == '1) sweeping <= 1'b0;
      end
   end

   assign in_ready = !sweeping && !rst;

   logic take;
   assign take    = in_valid && in_ready;
   assign rd_addr = in_id;

   // ---------------- update stages ----------------
   logic [PIPE-1:0]  st_v;
   logic [ID_W-1:0]  st_id  [PIPE];
   logic [INC_W-1:0] st_inc [PIPE];

   always_ff @(posedge clk) begin
      if (rst) begin
         st_v <= '0;
      end else begin
         st_v[0] <= take;
         for (int i = 1; i < PIPE; i++) st_v[i] <= st_v[i-1];
      end
   end

   always_ff @(posedge clk) begin
      st_id[0]  <= in_id;
      st_inc[0] <= in_inc;
      for (int i = 1; i < PIPE; i++) begin
         st_id[i]  <= st_id[i-1];
         st_inc[i] <= st_inc[i-1];
      end
   end

   // memory value read when the beat was accepted, carried to the last stage
   logic [CNT_W-1:0] tail_base;

   generate
      if (PIPE == 1) begin : g_base_direct
         assign tail_base = rd_data;
      end else begin : g_base_chain
         logic [CNT_W-1:0] base_q [PIPE-1];
         always_ff @(posedge clk) begin
            base_q[0] <= rd_data;
            for (int j = 1; j < PIPE - 1; j++) base_q[j] <= base_q[j-1];
         end
         assign tail_base = base_q[PIPE-2];
      end
   endgenerate

   // ---------------- write history for forwarding ----------------
   // entry 0 is the write of the most recent edge; PIPE entries span
   // exactly the writes a read issued at acceptance can have missed
   logic [PIPE-1:0]  hist_v;
   logic [ID_W-1:0]  hist_id  [PIPE];
   logic [CNT_W-1:0] hist_val [PIPE];

   logic             upd_we;
   logic [CNT_W-1:0] fwd_base;
   logic [CNT_W-1:0] sum;

   assign upd_we = st_v[LAST];

   always_comb begin
      fwd_base = tail_base;
      for (int k = PIPE - 1; k >= 0; k--) begin
         if (hist_v[k] && (hist_id[k] == st_id[LAST])) fwd_base = hist_val[k];
      end
   end

   assign sum = fwd_base + CNT_W'(st_inc[LAST]);

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_v <= '0;
      end else begin
         hist_v[0] <= upd_we;
         for (int k = 1; k < PIPE; k++) hist_v[k] <= hist_v[k-1];
      end
   end

   always_ff @(posedge clk) begin
      hist_id[0]  <= st_id[LAST];
      hist_val[0] <= sum;
      for (int k = 1; k < PIPE; k++) begin
         hist_id[k]  <= hist_id[k-1];
         hist_val[k] <= hist_val[k-1];
      end
   end

   assign wr_en   = upd_we || sweeping;
   assign wr_addr = sweeping ? sweep_idx : st_id[LAST];
   assign wr_data = sweeping ? '0 : sum;

   // ---------------- properties ----------------
   // R1: the clear walk advances one index per clock
   p_sweep_step_r1: assert property (@(posedge clk) disable iff (rst)
      (sweeping && $past(sweeping) && !$past(rst)) |->
         (wr_addr == ID_W'($past(wr_addr) + 1'b1)));

   // R1: no update is in flight while the walk runs
   p_sweep_alone_r1: assert property (@(posedge clk) disable iff (rst)
      sweeping |-> !upd_we);

   // R3: consecutive updates of one index chain without loss
   p_chain_r3: assert property (@(posedge clk) disable iff (rst)
      (upd_we && $past(upd_we) && (st_id[LAST] == $past(st_id[LAST]))) |->
         (wr_data == $past(wr_data) + CNT_W'(st_inc[LAST])));

   // R8: acceptance never drops once granted
   p_ready_holds_r8: assert property (@(posedge clk) disable iff (rst)
      in_ready |=> in_ready);

endmodule

// File: rtl/evcnt_lite_rd.sv
// Register-side read channel: one outstanding read, word select of wide counters.
module evcnt_lite_rd #(
   parameter int CNT_W  = 64,
   parameter int ID_W   = 8,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mem_ok,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [BUS_W-1:0]  rdata,
   output logic              rvalid,
   input  logic              rready,
   output logic              rb_en,
   output logic [ID_W-1:0]   rb_addr,
   input  logic [CNT_W-1:0]  rb_q
);
   localparam int SLOT_B  = evcnt_pkg::slot_bytes(CNT_W, BUS_W);
   localparam int SLOT_LG = evcnt_pkg::slot_lg(CNT_W, BUS_W);
   localparam int BUS_LG  = $clog2(BUS_W / 8);
   localparam int WORDS   = SLOT_B / (BUS_W / 8);

   logic ar_fire;

   assign arready = mem_ok && !rvalid;
   assign ar_fire = arvalid && arready;
   assign rb_en   = ar_fire;
   assign rb_addr = araddr[ADDR_W-1:SLOT_LG];

   always_ff @(posedge clk) begin
      if (rst)          rvalid <= 1'b0;
      else if (ar_fire) rvalid <= 1'b1;
      else if (rready)  rvalid <= 1'b0;
   end

   generate
      if (WORDS == 1) begin : g_one_word
         logic unused_off;
         assign unused_off = ^araddr[SLOT_LG-1:0];
         assign rdata      = BUS_W'(rb_q);
      end else begin : g_multi_word
         localparam int WIDX_W = SLOT_LG - BUS_LG;
         logic              unused_off;
         logic [WIDX_W-1:0] widx_q;
         assign unused_off = ^araddr[BUS_LG-1:0];
         always_ff @(posedge clk) begin
            if (ar_fire) widx_q <= araddr[SLOT_LG-1:BUS_LG];
         end
         assign rdata = rb_q[widx_q*BUS_W +: BUS_W];
      end
   endgenerate

   // R6: data is presented on the edge that takes the address
   p_read_latency_r6: assert property (@(posedge clk) disable iff (rst)
      ar_fire |=> rvalid);

   // R6: a stalled response keeps its data
   p_read_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (rvalid && !rready) |=> (rvalid && $stable(rdata)));

endmodule

// File: rtl/evcnt_lite_wr.sv
// Register-side write channel: pairs AW and W in any order, answers, discards.
module evcnt_lite_wr (
   input  logic clk,
   input  logic rst,
   input  logic awvalid,
   output logic awready,
   input  logic wvalid,
   output logic wready,
   output logic bvalid,
   input  logic bready
);
   logic aw_got, w_got;
   logic aw_fire, w_fire;

   assign awready = !aw_got && !bvalid;
   assign wready  = !w_got && !bvalid;
   assign aw_fire = awvalid && awready;
   assign w_fire  = wvalid && wready;

   always_ff @(posedge clk) begin
      if (rst) begin
         aw_got <= 1'b0;
         w_got  <= 1'b0;
         bvalid <= 1'b0;
      end else if (bvalid) begin
         if (bready) bvalid <= 1'b0;
      end else if ((aw_got || aw_fire) && (w_got || w_fire)) begin
         bvalid <= 1'b1;
         aw_got <= 1'b0;
         w_got  <= 1'b0;
      end else begin
         if (aw_fire) aw_got <= 1'b1;
         if (w_fire)  w_got  <= 1'b1;
      end
   end

   // R7: a pending response waits for the master
   p_resp_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (bvalid && !bready) |=> bvalid);

   // R7: one response per pair, never two in a row
   p_resp_once_r7: assert property (@(posedge clk) disable iff (rst)
      (bvalid && bready) |=> !bvalid);

endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank #(
   parameter int CNT_W  = 64,
   parameter int INC_W  = 16,
   parameter int ID_W   = 8,
   parameter int PIPE   = 2,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = ID_W + evcnt_pkg::slot_lg(CNT_W, BUS_W)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 inc_valid,
   output logic                 inc_ready,
   input  logic [INC_W-1:0]     inc_amount,
   input  logic [ID_W-1:0]      inc_id,
   input  logic [ADDR_W-1:0]    lite_awaddr,
   input  logic                 lite_awvalid,
   output logic                 lite_awready,
   input  logic [BUS_W-1:0]     lite_wdata,
   input  logic [BUS_W/8-1:0]   lite_wstrb,
   input  logic                 lite_wvalid,
   output logic                 lite_wready,
   output logic [1:0]           lite_bresp,
   output logic                 lite_bvalid,
   input  logic                 lite_bready,
   input  logic [ADDR_W-1:0]    lite_araddr,
   input  logic                 lite_arvalid,
   output logic                 lite_arready,
   output logic [BUS_W-1:0]     lite_rdata,
   output logic [1:0]           lite_rresp,
   output logic                 lite_rvalid,
   input  logic                 lite_rready
);
   localparam int SLOT_B  = evcnt_pkg::slot_bytes(CNT_W, BUS_W);
   localparam int SLOT_LG = evcnt_pkg::slot_lg(CNT_W, BUS_W);

   // ---------------- elaboration checks ----------------
   generate
      if (PIPE < 1) begin : g_bad_pipe
         $error("evcnt_bank: PIPE must be at least 1");
      end
      if ((CNT_W % 8) != 0 || CNT_W < INC_W) begin : g_bad_cnt
         $error("evcnt_bank: CNT_W must be whole bytes and no narrower than INC_W");
      end
      if (BUS_W != 32 && BUS_W != 64) begin : g_bad_bus
         $error("evcnt_bank: BUS_W must be 32 or 64");
      end
      if ((SLOT_B & (SLOT_B - 1)) != 0) begin : g_bad_slot
         $error("evcnt_bank: counter slot must be a power of two bytes");
      end
      if (CNT_W > BUS_W && (CNT_W % BUS_W) != 0) begin : g_bad_split
         $error("evcnt_bank: wide counters must be whole bus words");
      end
      if (ADDR_W != ID_W + SLOT_LG) begin : g_bad_addr
         $error("evcnt_bank: ADDR_W must equal ID_W plus slot address bits");
      end
   endgenerate

   // ---------------- interconnect ----------------
   logic             mem_we;
   logic [ID_W-1:0]  mem_waddr;
   logic [CNT_W-1:0] mem_wdata;
   logic [ID_W-1:0]  a_addr;
   logic [CNT_W-1:0] a_q;
   logic             b_en;
   logic [ID_W-1:0]  b_addr;
   logic [CNT_W-1:0] b_q;

   evcnt_mem #(.W(CNT_W), .AW(ID_W)) u_mem (
      .clk    (clk),
      .we     (mem_we),
      .waddr  (mem_waddr),
      .wdata  (mem_wdata),
      .a_addr (a_addr),
      .a_q    (a_q),
      .b_en   (b_en),
      .b_addr (b_addr),
      .b_q    (b_q)
   );

   evcnt_update #(.CNT_W(CNT_W), .INC_W(INC_W), .ID_W(ID_W), .PIPE(PIPE)) u_upd (
      .clk      (clk),
      .rst      (rst),
      .in_valid (inc_valid),
      .in_ready (inc_ready),
      .in_id    (inc_id),
      .in_inc   (inc_amount),
      .rd_addr  (a_addr),
      .rd_data  (a_q),
      .wr_en    (mem_we),
      .wr_addr  (mem_waddr),
      .wr_data  (mem_wdata)
   );

   evcnt_lite_rd #(.CNT_W(CNT_W), .ID_W(ID_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .mem_ok  (inc_ready),
      .araddr  (lite_araddr),
      .arvalid (lite_arvalid),
      .arready (lite_arready),
      .rdata   (lite_rdata),
      .rvalid  (lite_rvalid),
      .rready  (lite_rready),
      .rb_en   (b_en),
      .rb_addr (b_addr),
      .rb_q    (b_q)
   );

   evcnt_lite_wr u_wr (
      .clk     (clk),
      .rst     (rst),
      .awvalid (lite_awvalid),
      .awready (lite_awready),
      .wvalid  (lite_wvalid),
      .wready  (lite_wready),
      .bvalid  (lite_bvalid),
      .bready  (lite_bready)
   );

   assign lite_bresp = evcnt_pkg::RESP_OKAY;
   assign lite_rresp = evcnt_pkg::RESP_OKAY;

   // write payload is discarded by design (R7)
   logic unused_wr;
   assign unused_wr = ^{lite_awaddr, lite_wdata, lite_wstrb};

endmodule

// File: tb/evcnt_bank_tb.sv
module evcnt_bank_tb;
   localparam int N = 256;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst;
   int   n_chk = 0;
   int   n_bad = 0;
   logic tgt;   // 0: 64-bit instance, 1: 16-bit instance

   logic        s_valid;
   logic [7:0]  s_id;
   logic [15:0] s_amt;
   logic [10:0] ar_addr;
   logic        ar_valid, r_ready;
   logic [10:0] aw_addr;
   logic        aw_valid, w_valid, b_ready;
   logic [31:0] w_data;

   logic        m_ready, m_awready, m_wready, m_bvalid, m_arready, m_rvalid;
   logic [1:0]  m_bresp, m_rresp;
   logic [31:0] m_rdata;
   logic        n_ready, n_awready, n_wready, n_bvalid, n_arready, n_rvalid;
   logic [1:0]  n_bresp, n_rresp;
   logic [31:0] n_rdata;

   logic        cur_ready, cur_arready, cur_rvalid;
   logic [1:0]  cur_rresp;
   logic [31:0] cur_rdata;
   assign cur_ready   = tgt ? n_ready   : m_ready;
   assign cur_arready = tgt ? n_arready : m_arready;
   assign cur_rvalid  = tgt ? n_rvalid  : m_rvalid;
   assign cur_rresp   = tgt ? n_rresp   : m_rresp;
   assign cur_rdata   = tgt ? n_rdata   : m_rdata;

   logic [63:0] m_model [N];
   logic [15:0] n_model [N];

   evcnt_bank #(.CNT_W(64), .INC_W(16), .ID_W(8), .PIPE(2), .BUS_W(32), .ADDR_W(11)) u_dut (
      .clk(clk), .rst(rst),
      .inc_valid(s_valid && !tgt), .inc_ready(m_ready), .inc_amount(s_amt), .inc_id(s_id),
      .lite_awaddr(aw_addr), .lite_awvalid(aw_valid), .lite_awready(m_awready),
      .lite_wdata(w_data), .lite_wstrb(4'hF), .lite_wvalid(w_valid), .lite_wready(m_wready),
      .lite_bresp(m_bresp), .lite_bvalid(m_bvalid), .lite_bready(b_ready),
      .lite_araddr(ar_addr), .lite_arvalid(ar_valid && !tgt), .lite_arready(m_arready),
      .lite_rdata(m_rdata), .lite_rresp(m_rresp), .lite_rvalid(m_rvalid),
      .lite_rready(r_ready && !tgt)
   );

   evcnt_bank #(.CNT_W(16), .INC_W(16), .ID_W(8), .PIPE(2), .BUS_W(32), .ADDR_W(10)) u_narrow (
      .clk(clk), .rst(rst),
      .inc_valid(s_valid && tgt), .inc_ready(n_ready), .inc_amount(s_amt), .inc_id(s_id),
      .lite_awaddr(10'd0), .lite_awvalid(1'b0), .lite_awready(n_awready),
      .lite_wdata(32'd0), .lite_wstrb(4'h0), .lite_wvalid(1'b0), .lite_wready(n_wready),
      .lite_bresp(n_bresp), .lite_bvalid(n_bvalid), .lite_bready(1'b1),
      .lite_araddr(ar_addr[9:0]), .lite_arvalid(ar_valid && tgt), .lite_arready(n_arready),
      .lite_rdata(n_rdata), .lite_rresp(n_rresp), .lite_rvalid(n_rvalid),
      .lite_rready(r_ready && tgt)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic beat(input logic [7:0] id, input logic [15:0] amt);
      s_id = id; s_amt = amt; s_valid = 1'b1;
      while (!cur_ready) @(negedge clk);
      @(negedge clk);
      if (tgt) n_model[id] = n_model[id] + amt;
      else     m_model[id] = m_model[id] + 64'(amt);
   endtask

   task automatic quiet();
      s_valid = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic lite_read(input logic [10:0] a, input int hold, output logic [31:0] d);
      ar_addr = a; ar_valid = 1'b1;
      while (!cur_arready) @(negedge clk);
      @(negedge clk);
      ar_valid = 1'b0;
      check("R6", "rvalid after AR edge", 64'(cur_rvalid), 64'd1);
      check("R6", "rresp OKAY", 64'(cur_rresp), 64'd0);
      d = cur_rdata;
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         check("R6", "rvalid held", 64'(cur_rvalid), 64'd1);
         check("R6", "rdata stable", 64'(cur_rdata), 64'(d));
         check("R6", "arready low while pending", 64'(cur_arready), 64'd0);
      end
      r_ready = 1'b1;
      @(negedge clk);
      r_ready = 1'b0;
   endtask

   task automatic read64(input int id, output logic [63:0] v);
      logic [31:0] lo, hi;
      lite_read(11'(id * 8), 0, lo);
      lite_read(11'(id * 8 + 4), 0, hi);
      v = {hi, lo};
   endtask

   task automatic t_reset();
      int cnt;
      logic [63:0] v;
      logic [31:0] d;
      rst = 1'b1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      check("R1", "ready low as reset ends", 64'(m_ready), 64'd0);
      cnt = 0;
      while (!m_ready && cnt < 400) begin
         @(negedge clk);
         cnt++;
      end
      check("R1", "edges until ready", 64'(cnt), 64'(N));
      check("R1", "narrow ready", 64'(n_ready), 64'd1);
      read64(0, v);   check("R1", "counter 0 zero", v, 64'd0);
      read64(1, v);   check("R1", "counter 1 zero", v, 64'd0);
      read64(128, v); check("R1", "counter 128 zero", v, 64'd0);
      read64(255, v); check("R1", "counter 255 zero", v, 64'd0);
      tgt = 1'b1;
      lite_read(11'(255 * 4), 0, d); check("R1", "narrow 255 zero", 64'(d), 64'd0);
      tgt = 1'b0;
   endtask

   task automatic t_single();
      logic [63:0] v;
      beat(8'd7, 16'h0042); quiet();
      beat(8'd9, 16'h1000); s_valid = 1'b0; repeat (3) @(negedge clk);
      beat(8'd7, 16'h0101); quiet();
      read64(7, v); check("R2", "counter 7", v, 64'h143);
      read64(9, v); check("R2", "counter 9", v, 64'h1000);
      read64(8, v); check("R2", "neighbour 8 untouched", v, 64'd0);
   endtask

   task automatic t_b2b();
      logic [63:0] v;
      for (int i = 0; i < 20; i++) begin
         check("R8", "ready during burst", 64'(m_ready), 64'd1);
         beat(8'd20, 16'(i * 3 + 1));
      end
      quiet();
      read64(20, v); check("R3", "back-to-back total", v, m_model[20]);
      check("R3", "back-to-back literal", v, 64'd590);
   endtask

   task automatic t_interleave();
      logic [63:0] v;
      beat(8'd30, 16'd1); beat(8'd31, 16'd10); beat(8'd30, 16'd2);
      beat(8'd31, 16'd20); beat(8'd30, 16'd4); beat(8'd30, 16'd8);
      beat(8'd32, 16'd100); beat(8'd30, 16'd16);
      quiet();
      read64(30, v); check("R3", "interleave id30", v, 64'd31);
      read64(31, v); check("R3", "interleave id31", v, 64'd30);
      read64(32, v); check("R3", "interleave id32", v, 64'd100);
   endtask

   task automatic t_carry();
      logic [63:0] v;
      for (int i = 0; i < 65540; i++) beat(8'd200, 16'hFFFF);
      quiet();
      read64(200, v);
      check("R3", "carry into upper word", v, 64'h0000_0001_0002_FFFC);
      check("R3", "carry model", v, m_model[200]);
   endtask

   task automatic t_narrow();
      logic [31:0] d;
      tgt = 1'b1;
      beat(8'd3, 16'hFFFF); beat(8'd3, 16'h0003);
      quiet();
      lite_read(11'(3 * 4), 0, d); check("R4", "narrow wrap", 64'(d), 64'h2);
      lite_read(11'(3 * 4 + 2), 0, d); check("R5", "narrow low bits ignored", 64'(d), 64'h2);
      lite_read(11'(4 * 4), 0, d); check("R4", "narrow neighbour", 64'(d), 64'h0);
      tgt = 1'b0;
   endtask

   task automatic t_address();
      logic [31:0] d;
      logic [63:0] v;
      beat(8'd255, 16'h1234); beat(8'd255, 16'hABCD); beat(8'd0, 16'd7);
      quiet();
      lite_read(11'd2040, 0, d); check("R5", "id255 low word", 64'(d), 64'h0000BE01);
      lite_read(11'd2043, 0, d); check("R5", "id255 offset 3 ignored", 64'(d), 64'h0000BE01);
      lite_read(11'd2044, 0, d); check("R5", "id255 high word", 64'(d), 64'h0);
      read64(0, v);   check("R5", "id0", v, 64'd7);
      read64(254, v); check("R5", "id254 untouched", v, 64'd0);
      read64(200, v);
      lite_read(11'(200 * 8 + 5), 0, d); check("R5", "high word via offset 5", 64'(d), 64'h1);
   endtask

   task automatic t_read_hold();
      logic [31:0] d;
      lite_read(11'(7 * 8), 3, d);
      check("R6", "held read value", 64'(d), 64'h143);
   endtask

   task automatic lite_write(input int order, input int id);
      aw_addr = 11'(id * 8); w_data = 32'hFFFF_FFFF;
      if (order == 0 || order == 2) aw_valid = 1'b1;
      if (order == 1 || order == 2) w_valid = 1'b1;
      @(negedge clk);
      aw_valid = 1'b0; w_valid = 1'b0;
      if (order != 2) begin
         repeat (2) @(negedge clk);
         check("R7", "no response before pair", 64'(m_bvalid), 64'd0);
         if (order == 0) w_valid = 1'b1; else aw_valid = 1'b1;
         @(negedge clk);
         aw_valid = 1'b0; w_valid = 1'b0;
      end
      check("R7", "response after pair", 64'(m_bvalid), 64'd1);
      check("R7", "bresp OKAY", 64'(m_bresp), 64'd0);
      @(negedge clk);
      check("R7", "response held", 64'(m_bvalid), 64'd1);
      b_ready = 1'b1;
      @(negedge clk);
      b_ready = 1'b0;
      check("R7", "single response", 64'(m_bvalid), 64'd0);
   endtask

   task automatic t_write_ignored();
      logic [63:0] v;
      lite_write(0, 7);
      lite_write(1, 9);
      lite_write(2, 255);
      read64(7, v);   check("R7", "id7 after write", v, m_model[7]);
      read64(9, v);   check("R7", "id9 after write", v, m_model[9]);
      read64(255, v); check("R7", "id255 after write", v, m_model[255]);
   endtask

   task automatic t_concurrent();
      logic [63:0] v;
      fork
         begin
            for (int i = 0; i < 40; i++) begin
               check("R8", "ready with reads active", 64'(m_ready), 64'd1);
               beat(8'(10 + i % 3), 16'(i * 7 + 1));
            end
            s_valid = 1'b0;
         end
         begin
            logic [31:0] d;
            for (int k = 0; k < 4; k++) lite_read(11'(50 * 8), 1, d);
         end
      join
      quiet();
      read64(10, v); check("R8", "id10 total", v, m_model[10]);
      read64(11, v); check("R8", "id11 total", v, m_model[11]);
      read64(12, v); check("R8", "id12 total", v, m_model[12]);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_model[i] = '0;
         n_model[i] = '0;
      end
      tgt = 1'b0; rst = 1'b1;
      s_valid = 1'b0; s_id = '0; s_amt = '0;
      ar_addr = '0; ar_valid = 1'b0; r_ready = 1'b0;
      aw_addr = '0; aw_valid = 1'b0; w_valid = 1'b0; w_data = '0; b_ready = 1'b0;
      @(negedge clk);
      t_reset();
      t_single();
      t_b2b();
      t_interleave();
      t_narrow();
      t_carry();
      t_address();
      t_read_hold();
      t_write_ignored();
      t_concurrent();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule